// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets an on-chip requester read and write an external asynchronous static RAM of 65,536 words by 4 bits. The requester raises `req_valid` together with a direction flag, a 16-bit address and, for writes, a 4-bit data word. It holds them until `req_ready` pulses for one cycle. On a read, that pulse marks the cycle in which `rsp_rdata` carries the word taken from the memory. The controller drives the memory's active-low chip select, write enable and output enable, and the address. It also drives a 4-bit data bus whose tri-state drivers it switches through `mem_dq_oe`.

The nanosecond limits of the memory are parameters. Each is turned into a cycle count: the ceiling of the limit divided by the clock period, and never less than one. Every memory pin comes from a flop, so no pin can glitch. The state machine has seven states:
- **IDLE**: standby, chip select high.
- **TURN**: bus turnaround gap.
- **WSET**: write setup, with address, data and chip select presented.
- **WPUL**: write pulse, with write enable low.
- **WEND**: write end, with write enable raised and the drivers still on.
- **RACC**: read access, with chip select and output enable low.
- **RDONE**: read done.

The transitions are:
- IDLE→TURN on a request that reverses the direction of the previous operation.
- IDLE→WSET or IDLE→RACC on any other request.
- TURN→WSET or TURN→RACC when the gap count expires.
- WSET→WPUL after one cycle.
- WPUL→WEND when the pulse count expires.
- RACC→RDONE when the access count expires. The data bus is captured on this transition.
- WEND→IDLE and RDONE→IDLE, each after one cycle, which is the cycle `req_ready` is high.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is asserted, and in the cycle after it, chip select, write enable and output enable are high, the data drivers are off and `req_ready` is low.
- R2: With no request pending, the controller stays in IDLE with chip select high.
- R3: A read holds chip select and output enable low with write enable high and the drivers off. `rsp_rdata` then returns the word last written to that address, is valid while `req_ready` is high, and holds until the next read.
- R4: A read keeps output enable low for RD_CYC cycles, where RD_CYC is the largest of the cycle counts for address access (12 ns), chip-select access (12 ns) and output-enable access (6 ns). That is 2 cycles at 100 MHz. `req_ready` rises 1+RD_CYC clock edges after the accepting edge counts as the first.
- R5: A write drives the data with chip select low and output enable high. It then holds write enable low for exactly WP_CYC cycles, where WP_CYC is the largest of the counts for write pulse (9 ns), data setup (6 ns) and select-to-end (9 ns). That is 1 cycle at 100 MHz.
- R6: Write enable returns high while the data drivers are still on, so the drivers are released only after the write has ended.
- R7: The data drivers are never on while output enable is low.
- R8: When an operation reverses the direction of the previous one, TA_CYC idle cycles (memory release time of 6 ns, giving 1 cycle) are inserted. In these cycles chip select, write enable and output enable are all high, and the latency grows by TA_CYC. The first operation after reset gets no gap.
- R9: `req_ready` pulses high for exactly one cycle per request. For a write it rises 2+WP_CYC edges after the accepting edge counts as the first.
- R10: A request is accepted only in IDLE, and its address and data are latched there. Changes on `req_addr` or `req_wdata` during an operation have no effect on `mem_addr` or on the word stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request pending; held until `req_ready` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 4 | Write data |
| req_ready | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 4 | Captured read data |
| mem_addr | output | 16 | Memory address pins |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | 4 | Value for the data pins when driven |
| mem_dq_oe | output | 1 | Enable of the controller's data drivers |
| mem_dq_in | input | 4 | Value seen on the data pins |

## Verification
Directed writes and reads at addresses 0x0000 and 0xFFFF with data 0x0, 0xF, 0x5 and 0xA separate correct storage from bit or address aliasing at the extremes. Chains of read-read, write-write, read-write and write-read requests separate the plain latency from the latency with a turnaround gap, and show that the first operation after reset gets no gap. One request in each direction has its address and data scrambled after acceptance, which shows that the latched copy is used. A few hundred random operations over a narrow address window, with random idle gaps, then mix rewrites of the same location, standby periods and every direction change. The memory model answers only when chip select and output enable are low, so a read captured outside the access window, or a write that does not end with a write-enable rise, gives a wrong word.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_TURN  = 3'd1,
        ST_WSET  = 3'd2,
        ST_WPUL  = 3'd3,
        ST_WEND  = 3'd4,
        ST_RACC  = 3'd5,
        ST_RDONE = 3'd6
    } state_t;

    typedef struct packed {
        logic cs_n;
        logic we_n;
        logic oe_n;
        logic dq_oe;
    } pins_t;

    // Whole clock cycles covering a time limit, at least one.
    function automatic int cyc_of(input int lim_ns, input int per_ns);
        int c;
        c = (lim_ns + per_ns - 1) / per_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Pin levels belonging to each state.
    function automatic pins_t pins_of(input state_t s);
        pins_t p;
        p = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};
        unique case (s)
            ST_IDLE,
            ST_TURN,
            ST_RDONE: ;
            ST_WSET:  begin p.cs_n = 1'b0; p.dq_oe = 1'b1; end
            ST_WPUL:  begin p.cs_n = 1'b0; p.we_n = 1'b0; p.dq_oe = 1'b1; end
            ST_WEND:  begin p.cs_n = 1'b0; p.dq_oe = 1'b1; end
            ST_RACC:  begin p.cs_n = 1'b0; p.oe_n = 1'b0; end
            default: ;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/sram_tcnt.sv
module sram_tcnt #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/sram_pinreg.sv
module sram_pinreg
    import sram_ctrl_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  state_t        state_d,
    input  logic          accept,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] data_in,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_dq_out,
    output logic          mem_cs_n,
    output logic          mem_we_n,
    output logic          mem_oe_n,
    output logic          mem_dq_oe
);
    pins_t pins_d;
    pins_t pins_q;

    always_comb begin
        pins_d = pins_of(state_d);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pins_q <= '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};
        end else begin
            pins_q <= pins_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_addr   <= '0;
            mem_dq_out <= '0;
        end else if (accept) begin
            mem_addr   <= addr_in;
            mem_dq_out <= data_in;
        end
    end

    assign mem_cs_n  = pins_q.cs_n;
    assign mem_we_n  = pins_q.we_n;
    assign mem_oe_n  = pins_q.oe_n;
    assign mem_dq_oe = pins_q.dq_oe;
endmodule

// File: rtl/sram_rdcap.sv
module sram_rdcap #(
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout <= '0;
        end else if (cap) begin
            dout <= din;
        end
    end
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int AW        = 16,
    parameter int DW        = 4,
    parameter int T_CLK_NS  = 10,
    parameter int T_AA_NS   = 12,
    parameter int T_ACS_NS  = 12,
    parameter int T_OE_NS   = 6,
    parameter int T_WP_NS   = 9,
    parameter int T_CW_NS   = 9,
    parameter int T_DW_NS   = 6,
    parameter int T_HZ_NS   = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          req_ready,
    output logic [DW-1:0] rsp_rdata,
    output logic [AW-1:0] mem_addr,
    output logic          mem_cs_n,
    output logic          mem_we_n,
    output logic          mem_oe_n,
    output logic [DW-1:0] mem_dq_out,
    output logic          mem_dq_oe,
    input  logic [DW-1:0] mem_dq_in
);
    localparam int RD_CYC  = max_of(max_of(cyc_of(T_AA_NS, T_CLK_NS),
                                           cyc_of(T_ACS_NS, T_CLK_NS)),
                                    cyc_of(T_OE_NS, T_CLK_NS));
    localparam int WP_CYC  = max_of(max_of(cyc_of(T_WP_NS, T_CLK_NS),
                                           cyc_of(T_DW_NS, T_CLK_NS)),
                                    cyc_of(T_CW_NS, T_CLK_NS));
    localparam int TA_CYC  = cyc_of(T_HZ_NS, T_CLK_NS);
    localparam int CNT_MAX = max_of(max_of(RD_CYC, WP_CYC), TA_CYC);
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    localparam logic [CNT_W-1:0] RD_LD = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] WP_LD = CNT_W'(WP_CYC - 1);
    localparam logic [CNT_W-1:0] TA_LD = CNT_W'(TA_CYC - 1);

    state_t           state_q;
    state_t           state_d;
    logic             op_wr_q;
    logic             op_wr_d;
    logic             last_vld_q;
    logic             last_wr_q;
    logic             cnt_load;
    logic [CNT_W-1:0] cnt_val;
    logic             cnt_zero;
    logic             accept;
    logic             capture;

    // State register and operation bookkeeping.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            op_wr_q    <= 1'b0;
            last_vld_q <= 1'b0;
            last_wr_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            op_wr_q <= op_wr_d;
            if (state_q == ST_WEND) begin
                last_vld_q <= 1'b1;
                last_wr_q  <= 1'b1;
            end else if (state_q == ST_RDONE) begin
                last_vld_q <= 1'b1;
                last_wr_q  <= 1'b0;
            end
        end
    end

    // Next state and counter loads.
    always_comb begin
        state_d  = state_q;
        op_wr_d  = op_wr_q;
        cnt_load = 1'b0;
        cnt_val  = '0;
        accept   = 1'b0;
        capture  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    accept  = 1'b1;
                    op_wr_d = req_write;
                    if (last_vld_q && (last_wr_q != req_write)) begin
                        state_d  = ST_TURN;
                        cnt_load = 1'b1;
                        cnt_val  = TA_LD;
                    end else if (req_write) begin
                        state_d = ST_WSET;
                    end else begin
                        state_d  = ST_RACC;
                        cnt_load = 1'b1;
                        cnt_val  = RD_LD;
                    end
                end
            end
            ST_TURN: begin
                if (cnt_zero) begin
                    if (op_wr_q) begin
                        state_d = ST_WSET;
                    end else begin
                        state_d  = ST_RACC;
                        cnt_load = 1'b1;
                        cnt_val  = RD_LD;
                    end
                end
            end
            ST_WSET: begin
                state_d  = ST_WPUL;
                cnt_load = 1'b1;
                cnt_val  = WP_LD;
            end
            ST_WPUL: begin
                if (cnt_zero) begin
                    state_d = ST_WEND;
                end
            end
            ST_WEND: begin
                state_d = ST_IDLE;
            end
            ST_RACC: begin
                if (cnt_zero) begin
                    state_d = ST_RDONE;
                    capture = 1'b1;
                end
            end
            ST_RDONE: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Output process.
    always_comb begin
        req_ready = (state_q == ST_WEND) || (state_q == ST_RDONE);
    end

    sram_tcnt #(
        .CNT_W (CNT_W)
    ) u_tcnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .zero     (cnt_zero)
    );

    sram_pinreg #(
        .AW (AW),
        .DW (DW)
    ) u_pins (
        .clk        (clk),
        .rst_n      (rst_n),
        .state_d    (state_d),
        .accept     (accept),
        .addr_in    (req_addr),
        .data_in    (req_wdata),
        .mem_addr   (mem_addr),
        .mem_dq_out (mem_dq_out),
        .mem_cs_n   (mem_cs_n),
        .mem_we_n   (mem_we_n),
        .mem_oe_n   (mem_oe_n),
        .mem_dq_oe  (mem_dq_oe)
    );

    sram_rdcap #(
        .DW (DW)
    ) u_rdcap (
        .clk   (clk),
        .rst_n (rst_n),
        .cap   (capture),
        .din   (mem_dq_in),
        .dout  (rsp_rdata)
    );
endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
    parameter int AW     = 16,
    parameter int WP_CYC = 1,
    parameter int TA_CYC = 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_ready,
    input logic [AW-1:0] mem_addr,
    input logic          mem_cs_n,
    input logic          mem_we_n,
    input logic          mem_oe_n,
    input logic          mem_dq_oe
);
    logic [7:0] we_lo_cnt;
    logic [7:0] oe_hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_lo_cnt <= '0;
            oe_hi_cnt <= 8'hFF;
        end else begin
            we_lo_cnt <= mem_we_n ? 8'd0 : ((we_lo_cnt == 8'hFF) ? we_lo_cnt : we_lo_cnt + 8'd1);
            oe_hi_cnt <= !mem_oe_n ? 8'd0 : ((oe_hi_cnt == 8'hFF) ? oe_hi_cnt : oe_hi_cnt + 8'd1);
        end
    end

    // R1
    rst_pins_chk: assert property (@(posedge clk)
        !rst_n |=> (mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe && !req_ready));

    // R7
    no_contend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_dq_oe && !mem_oe_n));

    // R3
    read_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (!mem_cs_n && mem_we_n));

    // R5
    write_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_cs_n && mem_oe_n && mem_dq_oe));

    // R5
    we_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_lo_cnt == 8'(WP_CYC)));

    // R6
    drv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> mem_dq_oe);

    // R8
    turn_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> (oe_hi_cnt >= 8'(TA_CYC)));

    // R9
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> !req_ready);

    // R10
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));
endmodule

bind sram_ctrl sram_ctrl_chk #(
    .AW     (AW),
    .WP_CYC (WP_CYC),
    .TA_CYC (TA_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .mem_addr  (mem_addr),
    .mem_cs_n  (mem_cs_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_ctrl_test.sv
module sram_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [3:0]  req_wdata = '0;
    logic        req_ready;
    logic [3:0]  rsp_rdata;
    logic [15:0] mem_addr;
    logic        mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [3:0]  mem_dq_out;
    logic [3:0]  mem_dq_in;

    int total = 0;
    int bad = 0;
    int mdl_ver = 0;
    int we_lo = 0;
    logic have_last = 1'b0;
    logic last_wr = 1'b0;

    logic [3:0] mdl [logic [15:0]];
    logic [3:0] refm [logic [15:0]];

    always #5 clk = ~clk;

    sram_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_rdata(rsp_rdata), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    function automatic int cyc(input int ns);
        int c;
        c = (ns + 9) / 10;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int exp_rd();
        int a;
        a = cyc(12);
        if (cyc(6) > a) a = cyc(6);
        return a;
    endfunction

    function automatic int exp_wp();
        int a;
        a = cyc(9);
        if (cyc(6) > a) a = cyc(6);
        return a;
    endfunction

    function automatic logic [3:0] ref_get(input logic [15:0] a);
        return refm.exists(a) ? refm[a] : 4'h0;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Memory model: drives the bus only for a read decode.
    always @(mem_addr or mem_cs_n or mem_we_n or mem_oe_n or mdl_ver) begin
        if (!mem_cs_n && mem_we_n && !mem_oe_n)
            mem_dq_in = mdl.exists(mem_addr) ? mdl[mem_addr] : 4'h0;
        else
            mem_dq_in = 4'hC;
    end

    // Write happens at the end of the write enable pulse.
    always @(posedge mem_we_n) begin
        if (rst_n && !mem_cs_n) begin
            chk(mem_dq_oe == 1'b1, "R6", mem_dq_oe, 1);
            chk(we_lo == exp_wp(), "R5 pulse", we_lo, exp_wp());
            mdl[mem_addr] = mem_dq_out;
            mdl_ver++;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            we_lo = mem_we_n ? 0 : we_lo + 1;
            if (mem_dq_oe && !mem_oe_n) chk(1'b0, "R7", mem_oe_n, 1);
            if (!mem_we_n && (mem_cs_n || !mem_oe_n))
                chk(1'b0, "R5 ctx", {mem_cs_n, mem_oe_n}, 2'b01);
            if (!mem_oe_n && (mem_cs_n || !mem_we_n || mem_dq_oe))
                chk(1'b0, "R3 ctx", {mem_cs_n, mem_we_n, mem_dq_oe}, 3'b010);
        end
    end

    task automatic do_op(input bit wr, input logic [15:0] a, input logic [3:0] d, input bit scramble);
        int lat;
        int exp_lat;
        logic [3:0] exp_d;
        bit turn_seen;
        @(negedge clk);
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        req_valid = 1'b1;
        exp_lat = wr ? 2 + exp_wp() : 1 + exp_rd();
        if (have_last && (last_wr != wr)) exp_lat += cyc(6);
        lat = 0;
        turn_seen = 1'b0;
        forever begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            if (scramble) begin
                req_addr  = ~a;
                req_wdata = ~d;
            end
            if (mem_addr != a) chk(1'b0, "R10 addr", mem_addr, a);
            if (mem_cs_n && mem_we_n && mem_oe_n && !req_ready) turn_seen = 1'b1;
            if (req_ready || lat > 40) break;
        end
        req_valid = 1'b0;
        chk(lat == exp_lat, wr ? "R9 write latency" : "R4 read latency", lat, exp_lat);
        if (have_last && (last_wr != wr))
            chk(turn_seen, "R8 idle gap", turn_seen, 1);
        if (wr) begin
            refm[a] = d;
        end else begin
            exp_d = ref_get(a);
            chk(rsp_rdata == exp_d, "R3 data", rsp_rdata, exp_d);
        end
        have_last = 1'b1;
        last_wr = wr;
        @(negedge clk);
        chk(!req_ready, "R9 single pulse", req_ready, 0);
        if (!wr) chk(rsp_rdata == exp_d, "R3 hold", rsp_rdata, exp_d);
        chk(mem_cs_n && !mem_dq_oe, "R2 standby", {mem_cs_n, mem_dq_oe}, 2'b10);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk(mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe && !req_ready, "R1 in reset",
            {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, req_ready}, 5'b11100);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe && !req_ready, "R1 after reset",
            {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, req_ready}, 5'b11100);
        repeat (4) begin
            @(negedge clk);
            chk(mem_cs_n, "R2 idle", mem_cs_n, 1);
        end

        // Directed corners: first op without gap, extremes, chains.
        do_op(1'b0, 16'h0000, 4'h0, 1'b0);
        do_op(1'b1, 16'hFFFF, 4'hA, 1'b0);
        do_op(1'b1, 16'h0000, 4'h5, 1'b0);
        do_op(1'b1, 16'h8001, 4'hF, 1'b0);
        do_op(1'b0, 16'hFFFF, 4'h0, 1'b0);
        do_op(1'b0, 16'h0000, 4'h0, 1'b0);
        do_op(1'b0, 16'h8001, 4'h0, 1'b0);
        do_op(1'b1, 16'h1234, 4'h0, 1'b0);
        do_op(1'b0, 16'h1234, 4'h0, 1'b0);
        // R10: inputs change after acceptance.
        do_op(1'b1, 16'h0F0F, 4'h3, 1'b1);
        do_op(1'b0, 16'hF0F0, 4'h0, 1'b0);
        do_op(1'b0, 16'h0F0F, 4'h0, 1'b1);

        // Random mix over a narrow window.
        for (int i = 0; i < 300; i++) begin
            logic [15:0] a;
            a = 16'h4000 | 16'($urandom_range(0, 15));
            do_op(1'($urandom_range(0, 1)), a, 4'($urandom), 1'($urandom_range(0, 7) == 0));
            for (int g = 0; g < int'($urandom_range(0, 2)); g++) begin
                @(negedge clk);
                chk(mem_cs_n, "R2 gap", mem_cs_n, 1);
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule